// File: doc/BRIEF.md
# Transmit Loss-of-Signal Detector

This block watches the dual-rail data that the system side presents for transmission. It takes one sample per pulse interval, on a sample strobe, and decides whether the signal has been lost. A long enough unbroken run of empty intervals declares the loss. A mode input picks between a short and a long run length. Once the loss is declared, the block waits for a mark. That mark opens a fixed-length probe window. The window restores the signal only if it holds enough marks and never shows a long gap.

The live loss status feeds a sticky interrupt flag. The flag can be raised by the status going high only, or by any change of the status. Software clears the flag with a write-one-to-clear strobe, and a mask gates the interrupt line. Each new declaration also produces a single-clock event pulse, which an external error counter or a per-channel indicator can take.

The controlling state machine has four states:
- `ST_OFF`: the detector is disabled.
- `ST_WATCH`: the signal is present and zero runs are being counted.
- `ST_LOST`: loss is declared and the block waits for a mark.
- `ST_PROBE`: a clear window is running.

Its transitions are:
- enable (`ST_OFF`→`ST_WATCH`)
- declare (`ST_WATCH`→`ST_LOST`)
- open window (`ST_LOST`→`ST_PROBE`)
- restore (`ST_PROBE`→`ST_WATCH`)
- abandon (`ST_PROBE`→`ST_LOST`)
- disable (any state→`ST_OFF`)

Top module: `txlos_monitor`

## Requirements
- R1: While `dual_rail_en` is 0, the block sits in `ST_OFF`, `los_status` is 0 and the zero-run count is emptied. Leaving the enable low clears a declared loss one clock later.
- R2: A sample is taken only in a cycle with `sample_en` = 1. A sample is a mark when `tx_pos` or `tx_neg` is 1, and a zero otherwise. Loss is declared on the sample that completes a run of N consecutive zero samples. N is 32 when `long_crit` = 0 and 2048 when `long_crit` = 1.
- R3: In a declared loss, a mark opens a window of 32 samples, and that mark is the first sample. If the window holds at least 4 marks and no run of 16 zeros, the loss is cleared on its 32nd sample. If it holds fewer than 4 marks, the loss stays declared.
- R4: A run of 16 consecutive zeros inside a window abandons it at once. The next mark opens a fresh 32-sample window. Samples taken before the abandon do not count toward the new window.
- R5: `los_status` is 1 from the clock edge that takes the declaring sample until the clock edge that takes the clearing sample.
- R6: `int_sticky` is set one clock after `los_status` changes. When `irq_any_edge` = 0, only a 0-to-1 change sets it. When `irq_any_edge` = 1, either direction sets it.
- R7: An `irq_clr` pulse clears `int_sticky` at the next edge. If a setting change arrives at that same edge, the flag stays 1.
- R8: `int_out` equals `int_sticky` when `irq_mask` = 0, and is 0 when `irq_mask` = 1.
- R9: `los_event` is high for exactly one clock per declaration, in the first cycle that `los_status` is 1.
- R10: After reset, `los_status`, `int_sticky`, `int_out` and `los_event` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | One pulse interval is sampled in this cycle |
| tx_pos | input | 1 | Positive rail of the transmit data |
| tx_neg | input | 1 | Negative rail of the transmit data |
| dual_rail_en | input | 1 | Transmit interface is in a dual-rail format; enables detection |
| long_crit | input | 1 | 0: declare after 32 zeros; 1: declare after 2048 zeros |
| irq_any_edge | input | 1 | 0: flag on rising status; 1: flag on any status change |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| irq_clr | input | 1 | Write-one-to-clear strobe for the sticky flag |
| los_status | output | 1 | Live loss-of-signal status |
| int_sticky | output | 1 | Sticky interrupt status |
| int_out | output | 1 | Masked interrupt request |
| los_event | output | 1 | One-clock pulse on each declaration, for an error counter |

## Verification
Several kinds of stimulus are used, and each tells apart a different pair of behaviours.

- Zero runs that stop one sample short of the limit, and runs that reach it exactly, are tried in both length modes. These separate a correct declaration point from an off-by-one.
- Runs broken up by idle cycles of the sample strobe show whether unsampled cycles are wrongly counted.
- Clear windows carry three marks or four, and some contain a 16-zero gap followed by dense marks. These tell a proper density check from a bare mark count, and an abandoned window from one that keeps its earlier samples.
- Long pseudo-random streams at mark densities from one half down to one in thirty-two are run with the edge mode, the mask and the clear strobe changing along the way. Every cycle is compared against an arithmetic model.

// File: rtl/txlos_pkg.sv
package txlos_pkg;

    // Controller states of the loss-of-signal detector
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // detection disabled
        ST_WATCH = 2'd1,   // signal present, zero runs counted
        ST_LOST  = 2'd2,   // loss declared, waiting for a mark
        ST_PROBE = 2'd3    // clear window in progress
    } los_state_t;

endpackage

// File: rtl/txlos_zero_run.sv
module txlos_zero_run #(
    parameter int SHORT_N = 32,
    parameter int LONG_N  = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic sample,
    input  logic mark,
    input  logic long_crit,
    output logic hit
);
    localparam int MAX_N = (LONG_N > SHORT_N) ? LONG_N : SHORT_N;
    localparam int CW    = $clog2(MAX_N + 1);
    localparam logic [CW-1:0] SHORT_L = CW'(SHORT_N);
    localparam logic [CW-1:0] LONG_L  = CW'(LONG_N);
    localparam logic [CW-1:0] SAT_L   = CW'(MAX_N);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_n;
    logic [CW-1:0] limit;

    // Next run length: cleared by a mark, saturating on zeros
    always_comb begin
        limit = long_crit ? LONG_L : SHORT_L;
        run_n = run_q;
        if (sample) begin
            if (mark) begin
                run_n = '0;
            end else if (run_q < SAT_L) begin
                run_n = run_q + 1'b1;
            end
        end
        hit = sample && !mark && (run_n >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (flush) begin
            run_q <= '0;
        end else begin
            run_q <= run_n;
        end
    end

endmodule

// File: rtl/txlos_probe_window.sv
module txlos_probe_window #(
    parameter int WIN_M      = 32,
    parameter int MIN_MARKS  = 4,
    parameter int ZRUN_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    input  logic mark,
    input  logic in_probe,
    output logic pass,
    output logic fail
);
    localparam int WW = $clog2(WIN_M + 1);
    localparam int ZW = $clog2(ZRUN_LIMIT + 1);
    localparam logic [WW-1:0] WIN_L  = WW'(WIN_M);
    localparam logic [WW-1:0] MARK_L = WW'(MIN_MARKS);
    localparam logic [ZW-1:0] ZRUN_L = ZW'(ZRUN_LIMIT);

    logic [WW-1:0] wcnt_q, wcnt_n;
    logic [WW-1:0] mcnt_q, mcnt_n;
    logic [ZW-1:0] zcnt_q, zcnt_n;
    logic          gap_hit;
    logic          win_end;

    always_comb begin
        wcnt_n  = wcnt_q + 1'b1;
        mcnt_n  = mcnt_q + WW'(mark);
        zcnt_n  = mark ? '0 : zcnt_q + 1'b1;
        gap_hit = zcnt_n >= ZRUN_L;
        win_end = wcnt_n == WIN_L;
        // A long gap abandons the window before density is judged
        fail = step && (gap_hit || (win_end && (mcnt_n < MARK_L)));
        pass = step && !gap_hit && win_end && (mcnt_n >= MARK_L);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            mcnt_q <= '0;
            zcnt_q <= '0;
        end else if (start) begin
            wcnt_q <= WW'(1);
            mcnt_q <= WW'(1);
            zcnt_q <= '0;
        end else if (step) begin
            wcnt_q <= wcnt_n;
            mcnt_q <= mcnt_n;
            zcnt_q <= zcnt_n;
        end
    end

    // R4
    probe_gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_probe |-> (zcnt_q < ZRUN_L));

    // R3
    probe_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_probe |-> (wcnt_q < WIN_L) && (wcnt_q != '0));

endmodule

// File: rtl/txlos_irq.sv
module txlos_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic stat,
    input  logic any_edge,
    input  logic clr,
    input  logic mask,
    output logic sticky,
    output logic irq
);
    logic stat_d;
    logic sticky_q;
    logic set_ev;

    always_comb begin
        set_ev = any_edge ? (stat ^ stat_d) : (stat & ~stat_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_d   <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            stat_d <= stat;
            if (set_ev) begin
                sticky_q <= 1'b1;
            end else if (clr) begin
                sticky_q <= 1'b0;
            end
        end
    end

    assign sticky = sticky_q;
    assign irq    = sticky_q & ~mask;

    // R6
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat) |=> sticky);

    // R6
    fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat) && !any_edge && !clr) |=> (sticky == $past(sticky)));

    // R7
    clr_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && $stable(stat)) |=> !sticky);

endmodule

// File: rtl/txlos_monitor.sv
module txlos_monitor
    import txlos_pkg::*;
#(
    parameter int SHORT_N    = 32,
    parameter int LONG_N     = 2048,
    parameter int WIN_M      = 32,
    parameter int MIN_MARKS  = 4,
    parameter int ZRUN_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic dual_rail_en,
    input  logic long_crit,
    input  logic irq_any_edge,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic los_status,
    output logic int_sticky,
    output logic int_out,
    output logic los_event
);
    los_state_t st_q, st_d;
    logic mark;
    logic run_hit;
    logic win_start, win_step, win_pass, win_fail;
    logic declare;
    logic event_q;
    logic in_probe;

    assign mark     = tx_pos | tx_neg;
    assign in_probe = (st_q == ST_PROBE);

    txlos_zero_run #(
        .SHORT_N (SHORT_N),
        .LONG_N  (LONG_N)
    ) u_zrun (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!dual_rail_en),
        .sample    (sample_en),
        .mark      (mark),
        .long_crit (long_crit),
        .hit       (run_hit)
    );

    txlos_probe_window #(
        .WIN_M      (WIN_M),
        .MIN_MARKS  (MIN_MARKS),
        .ZRUN_LIMIT (ZRUN_LIMIT)
    ) u_probe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (win_start),
        .step     (win_step),
        .mark     (mark),
        .in_probe (in_probe),
        .pass     (win_pass),
        .fail     (win_fail)
    );

    // Transition conditions
    always_comb begin
        win_start = dual_rail_en && (st_q == ST_LOST) && sample_en && mark;
        win_step  = dual_rail_en && (st_q == ST_PROBE) && sample_en;
        declare   = dual_rail_en && (st_q == ST_WATCH) && run_hit;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (!dual_rail_en) begin
            st_d = ST_OFF;                         // disable
        end else begin
            unique case (st_q)
                ST_OFF:   st_d = ST_WATCH;         // enable
                ST_WATCH: if (declare)   st_d = ST_LOST;   // declare
                ST_LOST:  if (win_start) st_d = ST_PROBE;  // open window
                ST_PROBE: begin
                    if (win_pass)      st_d = ST_WATCH;    // restore
                    else if (win_fail) st_d = ST_LOST;     // abandon
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q <= 1'b0;
        end else begin
            event_q <= declare;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_LOST, ST_PROBE: los_status = 1'b1;
            default:           los_status = 1'b0;
        endcase
        los_event = event_q;
    end

    txlos_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (los_status),
        .any_edge (irq_any_edge),
        .clr      (irq_clr),
        .mask     (irq_mask),
        .sticky   (int_sticky),
        .irq      (int_out)
    );

    // R1
    off_holds_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_rail_en |=> !los_status);

    // R9
    event_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        los_event |-> (los_status && !$past(los_status)));

    // R8
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> !irq_mask);

endmodule

// File: tb/txlos_monitor_test.sv
module txlos_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_N = 32;
    localparam int LONG_N  = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
    logic dual_rail_en = 1'b0, long_crit = 1'b0;
    logic irq_any_edge = 1'b0, irq_mask = 1'b0, irq_clr = 1'b0;
    logic los_status, int_sticky, int_out, los_event;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R5";

    // reference model state
    int m_state = 0;   // 0 off, 1 watch, 2 lost, 3 probe
    int m_zrun = 0, m_wc = 0, m_mc = 0, m_wz = 0;
    bit m_stat = 0, m_stat_d = 0, m_sticky = 0, m_event = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txlos_monitor uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .dual_rail_en(dual_rail_en),
        .long_crit(long_crit), .irq_any_edge(irq_any_edge),
        .irq_mask(irq_mask), .irq_clr(irq_clr),
        .los_status(los_status), .int_sticky(int_sticky),
        .int_out(int_out), .los_event(los_event)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit ev;
        bit mk;
        int zn;
        int lim;
        ev = irq_any_edge ? (m_stat != m_stat_d) : (m_stat && !m_stat_d);
        if (ev) m_sticky = 1;
        else if (irq_clr) m_sticky = 0;
        m_stat_d = m_stat;
        m_event = 0;
        mk = tx_pos | tx_neg;
        lim = long_crit ? LONG_N : SHORT_N;
        if (!dual_rail_en) begin
            m_state = 0;
            m_zrun = 0;
        end else begin
            zn = m_zrun;
            if (sample_en) zn = mk ? 0 : ((m_zrun < LONG_N) ? m_zrun + 1 : m_zrun);
            case (m_state)
                0: m_state = 1;
                1: if (sample_en && !mk && zn >= lim) begin m_state = 2; m_event = 1; end
                2: if (sample_en && mk) begin m_state = 3; m_wc = 1; m_mc = 1; m_wz = 0; end
                default: if (sample_en) begin
                    m_wc++;
                    if (mk) begin m_mc++; m_wz = 0; end else m_wz++;
                    if (m_wz >= 16) m_state = 2;
                    else if (m_wc == 32) m_state = (m_mc >= 4) ? 1 : 2;
                end
            endcase
            m_zrun = zn;
        end
        m_stat = (m_state >= 2);
    endtask

    task automatic compare();
        chk(cur_req, los_status, m_stat, "los_status vs model (R5)");
        chk(cur_req, los_event, m_event, "los_event vs model (R9)");
        chk(cur_req, int_sticky, m_sticky, "int_sticky vs model (R6)");
        chk(cur_req, int_out, m_sticky & ~irq_mask, "int_out vs model (R8)");
    endtask

    task automatic cyc(input logic en, input logic p, input logic n, input logic clr);
        @(negedge clk);
        sample_en = en; tx_pos = p; tx_neg = n; irq_clr = clr;
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        compare();
    endtask

    task automatic zeros(input int k);
        for (int i = 0; i < k; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic marks(input int k);
        for (int i = 0; i < k; i++) cyc(1'b1, i[0], ~i[0], 1'b0);
    endtask

    task automatic good_window();
        for (int g = 0; g < 4; g++) begin
            marks(1);
            zeros(7);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        // R10 reset state
        #(CLK_PERIOD*3);
        chk("R10", los_status, 1'b0, "status in reset");
        chk("R10", int_sticky, 1'b0, "sticky in reset");
        chk("R10", int_out, 1'b0, "irq in reset");
        chk("R10", los_event, 1'b0, "event in reset");
        @(negedge clk);
        rst_n = 1'b1;
        dual_rail_en = 1'b1;

        // R2 short declaration boundary
        cur_req = "R2";
        zeros(31);
        chk("R2", los_status, 1'b0, "31 zeros no loss");
        zeros(1);
        chk("R2", los_status, 1'b1, "32 zeros loss");
        chk("R9", los_event, 1'b1, "event with declaration");
        // R7 clear strobe coinciding with set
        cur_req = "R7";
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R7", int_sticky, 1'b1, "set wins over clear");
        chk("R9", los_event, 1'b0, "event one clock only");
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R7", int_sticky, 1'b0, "clear strobe");

        // R3 clear with four marks
        cur_req = "R3";
        marks(1); zeros(7); marks(1); zeros(7); marks(1); zeros(7); marks(1); zeros(6);
        chk("R3", los_status, 1'b1, "window not complete");
        zeros(1);
        chk("R3", los_status, 1'b0, "clear after 32 with 4 marks");

        // R3 density shortfall
        zeros(40);
        marks(1); zeros(10); marks(1); zeros(10); marks(1); zeros(9);
        chk("R3", los_status, 1'b1, "3 marks keep loss");
        good_window();
        chk("R3", los_status, 1'b0, "following dense window clears");

        // R4 abandon on 16-zero gap
        cur_req = "R4";
        zeros(40);
        marks(4); zeros(16); marks(12);
        chk("R4", los_status, 1'b1, "abandoned window not completed");
        marks(20);
        chk("R4", los_status, 1'b0, "fresh window clears");

        // R6 edge selection
        cur_req = "R6";
        irq_any_edge = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        zeros(40);
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        good_window();
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6", int_sticky, 1'b0, "fall ignored in rise mode");
        irq_any_edge = 1'b1;
        zeros(40);
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R6", int_sticky, 1'b0, "cleared before fall");
        good_window();
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R6", int_sticky, 1'b1, "fall sets in any-edge mode");

        // R8 mask
        cur_req = "R8";
        irq_mask = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8", int_out, 1'b0, "masked");
        irq_mask = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8", int_out, 1'b1, "unmasked");

        // R1 disabled detector
        cur_req = "R1";
        zeros(40);
        dual_rail_en = 1'b0;
        zeros(1);
        chk("R1", los_status, 1'b0, "disable clears loss");
        zeros(60);
        chk("R1", los_status, 1'b0, "no declaration while disabled");
        dual_rail_en = 1'b1;

        // R2 sample strobe gaps
        cur_req = "R2";
        zeros(20);
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        zeros(11);
        chk("R2", los_status, 1'b0, "unsampled cycles not counted");
        zeros(1);
        chk("R2", los_status, 1'b1, "32nd sampled zero declares");

        // R2 long mode boundary
        dual_rail_en = 1'b0;
        zeros(1);
        dual_rail_en = 1'b1;
        long_crit = 1'b1;
        zeros(LONG_N - 1);
        chk("R2", los_status, 1'b0, "2047 zeros no loss in long mode");
        zeros(1);
        chk("R2", los_status, 1'b1, "2048 zeros loss in long mode");
        good_window();
        chk("R3", los_status, 1'b0, "clear in long mode");
        long_crit = 1'b0;

        // Pseudo-random sweeps at several mark densities
        lfsr = 16'hACE1;
        for (int d = 0; d < 5; d++) begin
            cur_req = (d % 2 == 0) ? "R3" : "R4";
            irq_any_edge = d[0];
            for (int i = 0; i < 3000; i++) begin
                logic mk;
                logic [15:0] sel;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sel = lfsr & ((16'd1 << (d + 1)) - 16'd1);
                mk = (sel == 16'd0);
                irq_mask = lfsr[7] & lfsr[3];
                cyc(lfsr[9] | lfsr[4], mk & lfsr[2], mk & ~lfsr[2], lfsr[11] & lfsr[5] & lfsr[1]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule